// File: doc/BRIEF.md
# PLL Holdover and Lock Supervisor

This block watches the digital lock-detect indication of a phase-locked loop and turns it into a qualified lock flag. The qualified flag counts consecutive cycles in which the lock-detect input is high and asserts only after a programmable number of them. A single low sample clears the count at once.

When the lock-detect input falls, the loop has left lock, and the supervisor decides what to do next. It enters holdover only under three conditions: holdover is enabled, no reference is present, and the loss passes qualification. Qualification means the qualified lock flag was high in the cycle the fall was seen, or the qualification check is switched off. In holdover the charge pump is forced to high impedance, and the divider counters outside keep running. The first reference-path phase-detector event seen with the reference present ends holdover. In the cycle the charge pump is released, a one-cycle reset pulse goes to the feedback B counter, so the divider edges line up again. A loss that does not lead to holdover raises a loss-of-lock flag. The flag stays up until qualified lock returns.

The charge pump, the loop filter and the divider counters are outside this block. All inputs are taken as synchronous to `clk`.

Top module: `pll_holdover_ctrl`

## Requirements
- R1: While reset is applied and after it is released, with no stimulus, cp_hiz_o, fb_cnt_rst_o, holdover_o, lock_ok_o and lock_lost_o are all 0.
- R2: lock_ok_o becomes 1 after dld_i has been sampled high on N consecutive clock edges, where N is lock_tc_i (a value of 0 acts as 1). It stays 1 while dld_i stays high.
- R3: A falling dld_i (sampled high, then low on the next edge) enters holdover when three things hold at that edge: hold_en_i=1, ref_present_i=0, and either lock_qual_en_i=0 or lock_ok_o=1. holdover_o and cp_hiz_o are 1 from the cycle after that edge.
- R4: A falling dld_i that does not meet the R3 conditions leaves holdover_o and cp_hiz_o at 0. Such a case is a present reference, a failed qualification, or holdover disabled. It sets lock_lost_o after that edge. lock_lost_o clears on the edge after lock_ok_o has been sampled 1.
- R5: In holdover, a phase-detector event that arrives while ref_present_i=0 is ignored, and so is any dld_i activity. holdover_o and cp_hiz_o stay 1.
- R6: In holdover, ref_pfd_evt_i=1 together with ref_present_i=1 ends holdover on that edge. In the next cycle cp_hiz_o and holdover_o are 0 and fb_cnt_rst_o is 1, for exactly one cycle.
- R7: Lock integration keeps running during holdover, so lock_ok_o can rise while holdover_o is 1.
- R8: Any single low sample of dld_i drops lock_ok_o on the next edge and restarts the count. A full N high samples are needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dld_i | input | 1 | Digital lock-detect level from the phase detector |
| ref_present_i | input | 1 | Reference clock present status |
| ref_pfd_evt_i | input | 1 | One-cycle strobe for a reference-path phase-detector event |
| hold_en_i | input | 1 | Allows holdover entry |
| lock_qual_en_i | input | 1 | 1: entry needs qualified lock; 0: lock counts as always qualified |
| lock_tc_i | input | LOCK_CNT_W | Terminal count of the lock integrator |
| cp_hiz_o | output | 1 | Forces the charge pump to high impedance |
| fb_cnt_rst_o | output | 1 | One-cycle synchronous reset for the feedback B counter |
| holdover_o | output | 1 | Holdover active status |
| lock_ok_o | output | 1 | Qualified lock indication |
| lock_lost_o | output | 1 | Lock was lost without holdover entry |

## Verification
Every result is registered, so each one appears one edge after the stimulus that causes it. The exception is the qualified lock, which appears N edges after dld_i rises. The reset pulse and the charge-pump release share one edge. Inputs change on the falling clock edge. Each check waits the exact number of rising edges its requirement gives and then samples at the next falling edge. Checks made one edge early confirm that an output has not yet moved.

// File: rtl/phc_pkg.sv
package phc_pkg;
  typedef enum logic [0:0] {
    PHC_TRACK = 1'b0,
    PHC_HOLD  = 1'b1
  } phc_state_e;
endpackage

// File: rtl/phc_rst_sync.sv
module phc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= 1'b1;
      ff2_q <= ff1_q;
    end
  end

  assign rst_n_s = ff2_q;
endmodule

// File: rtl/phc_lock_integ.sv
module phc_lock_integ #(
  parameter int LOCK_CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dld,
  input  logic [LOCK_CNT_W-1:0] tc,
  output logic                  lock_ok
);
  localparam logic [LOCK_CNT_W-1:0] ONE = LOCK_CNT_W'(1);

  logic [LOCK_CNT_W-1:0] cnt_q, cnt_d;
  logic [LOCK_CNT_W-1:0] eff_tc;
  logic                  cnt_en;

  // terminal count of zero behaves like one
  always_comb begin
    eff_tc = (tc == '0) ? ONE : tc;
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!dld) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q < eff_tc) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign lock_ok = (cnt_q >= eff_tc);
endmodule

// File: rtl/phc_dld_edge.sv
module phc_dld_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic dld,
  output logic dld_fall
);
  logic dld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dld_q <= 1'b0;
    end else begin
      dld_q <= dld;
    end
  end

  assign dld_fall = dld_q & ~dld;
endmodule

// File: rtl/phc_hold_fsm.sv
module phc_hold_fsm
  import phc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dld_fall,
  input  logic lock_ok,
  input  logic lock_qual_en,
  input  logic hold_en,
  input  logic ref_present,
  input  logic pfd_evt,
  output logic cp_hiz,
  output logic fb_cnt_rst,
  output logic holdover,
  output logic lock_lost
);
  phc_state_e state_q, state_d;
  logic       rst_pulse_d, rst_pulse_q;
  logic       lost_d, lost_q;
  logic       qual_ok;
  logic       enter_hold;
  logic       release_hold;

  always_comb begin
    qual_ok      = lock_ok | ~lock_qual_en;
    enter_hold   = dld_fall & hold_en & ~ref_present & qual_ok;
    release_hold = pfd_evt & ref_present;
  end

  always_comb begin
    state_d     = state_q;
    rst_pulse_d = 1'b0;
    lost_d      = lost_q;
    unique case (state_q)
      PHC_TRACK: begin
        if (enter_hold) begin
          state_d = PHC_HOLD;
        end else if (dld_fall) begin
          lost_d = 1'b1;
        end else if (lock_ok) begin
          lost_d = 1'b0;
        end
      end
      PHC_HOLD: begin
        if (release_hold) begin
          state_d     = PHC_TRACK;
          rst_pulse_d = 1'b1;
        end
      end
      default: state_d = PHC_TRACK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PHC_TRACK;
      rst_pulse_q <= 1'b0;
      lost_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      rst_pulse_q <= rst_pulse_d;
      lost_q      <= lost_d;
    end
  end

  assign holdover   = (state_q == PHC_HOLD);
  assign cp_hiz     = (state_q == PHC_HOLD);
  assign fb_cnt_rst = rst_pulse_q;
  assign lock_lost  = lost_q;
endmodule

// File: rtl/pll_holdover_ctrl.sv
module pll_holdover_ctrl #(
  parameter int LOCK_CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dld_i,
  input  logic                  ref_present_i,
  input  logic                  ref_pfd_evt_i,
  input  logic                  hold_en_i,
  input  logic                  lock_qual_en_i,
  input  logic [LOCK_CNT_W-1:0] lock_tc_i,
  output logic                  cp_hiz_o,
  output logic                  fb_cnt_rst_o,
  output logic                  holdover_o,
  output logic                  lock_ok_o,
  output logic                  lock_lost_o
);
  logic rst_n_s;
  logic dld_fall;
  logic lock_ok;

  phc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  phc_lock_integ #(.LOCK_CNT_W(LOCK_CNT_W)) u_integ (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .dld     (dld_i),
    .tc      (lock_tc_i),
    .lock_ok (lock_ok)
  );

  phc_dld_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .dld      (dld_i),
    .dld_fall (dld_fall)
  );

  phc_hold_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .dld_fall     (dld_fall),
    .lock_ok      (lock_ok),
    .lock_qual_en (lock_qual_en_i),
    .hold_en      (hold_en_i),
    .ref_present  (ref_present_i),
    .pfd_evt      (ref_pfd_evt_i),
    .cp_hiz       (cp_hiz_o),
    .fb_cnt_rst   (fb_cnt_rst_o),
    .holdover     (holdover_o),
    .lock_lost    (lock_lost_o)
  );

  assign lock_ok_o = lock_ok;
endmodule

// File: rtl/pll_holdover_ctrl_chk.sv
module pll_holdover_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic dld,
  input logic ref_present,
  input logic pfd_evt,
  input logic lock_qual_en,
  input logic lock_ok,
  input logic cp_hiz,
  input logic fb_cnt_rst,
  input logic holdover
);
  AST_DLD_LOW_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !dld |=> !lock_ok); // R8
  AST_ENTRY_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdover) |-> (!$past(lock_qual_en) || $past(lock_ok))); // R3
  AST_ENTRY_NO_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdover) |-> !$past(ref_present)); // R4
  AST_HOLD_WAITS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover && !(pfd_evt && ref_present)) |=> (holdover && cp_hiz)); // R5
  AST_RST_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    fb_cnt_rst |-> ($past(cp_hiz) && !cp_hiz)); // R6
  AST_RELEASE_GIVES_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cp_hiz) |-> fb_cnt_rst); // R6
endmodule

bind pll_holdover_ctrl pll_holdover_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n_s),
  .dld          (dld_i),
  .ref_present  (ref_present_i),
  .pfd_evt      (ref_pfd_evt_i),
  .lock_qual_en (lock_qual_en_i),
  .lock_ok      (lock_ok_o),
  .cp_hiz       (cp_hiz_o),
  .fb_cnt_rst   (fb_cnt_rst_o),
  .holdover     (holdover_o)
);

// File: tb/pll_holdover_ctrl_tb_top.sv
`timescale 1ns/1ps
module pll_holdover_ctrl_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dld = 1'b0;
  logic         refp = 1'b1;
  logic         evt = 1'b0;
  logic         hen = 1'b1;
  logic         qen = 1'b1;
  logic [W-1:0] tc = 8'd4;
  logic         cp_hiz, fbrst, hold, lock_ok, lost;
  int           total = 0;
  int           bad = 0;

  always #10 clk = ~clk;

  pll_holdover_ctrl #(.LOCK_CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .dld_i(dld), .ref_present_i(refp),
    .ref_pfd_evt_i(evt), .hold_en_i(hen), .lock_qual_en_i(qen),
    .lock_tc_i(tc), .cp_hiz_o(cp_hiz), .fb_cnt_rst_o(fbrst),
    .holdover_o(hold), .lock_ok_o(lock_ok), .lock_lost_o(lost)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dld = 1'b0; refp = 1'b1; evt = 1'b0;
    hen = 1'b1; qen = 1'b1; tc = 8'd4;
    step(2);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    step(1);
    chk("R1 hiz in reset", cp_hiz, 1'b0);
    chk("R1 lock in reset", lock_ok, 1'b0);
    do_reset();
    chk("R1 hiz", cp_hiz, 1'b0);
    chk("R1 fbrst", fbrst, 1'b0);
    chk("R1 hold", hold, 1'b0);
    chk("R1 lock", lock_ok, 1'b0);
    chk("R1 lost", lost, 1'b0);
  endtask

  task automatic t_lock_integrate();
    do_reset();
    tc = 8'd5; dld = 1'b1;
    step(4);
    chk("R2 not yet locked", lock_ok, 1'b0);
    step(1);
    chk("R2 locked after tc", lock_ok, 1'b1);
    step(3);
    chk("R2 lock held", lock_ok, 1'b1);
    // R8 glitch: one low sample
    dld = 1'b0;
    step(1);
    chk("R8 glitch drops lock", lock_ok, 1'b0);
    dld = 1'b1;
    step(4);
    chk("R8 count restarted", lock_ok, 1'b0);
    step(1);
    chk("R8 relock after full count", lock_ok, 1'b1);
    // R2 terminal count zero acts as one
    dld = 1'b0; tc = 8'd0;
    step(1);
    dld = 1'b1;
    step(1);
    chk("R2 tc zero locks after one", lock_ok, 1'b1);
  endtask

  task automatic t_holdover_cycle();
    do_reset();
    tc = 8'd3; dld = 1'b1;
    step(3);
    chk("R3 lock before loss", lock_ok, 1'b1);
    refp = 1'b0; dld = 1'b0;
    step(1);
    chk("R3 enter hold", hold, 1'b1);
    chk("R3 hiz on entry", cp_hiz, 1'b1);
    chk("R4 lost not set on hold", lost, 1'b0);
    evt = 1'b1;
    step(1);
    evt = 1'b0;
    chk("R5 evt without ref ignored", hold, 1'b1);
    dld = 1'b1;
    step(3);
    chk("R7 lock during hold", lock_ok, 1'b1);
    chk("R7 still hold", hold, 1'b1);
    dld = 1'b0;
    step(1);
    chk("R5 dld fall in hold ignored", cp_hiz, 1'b1);
    refp = 1'b1;
    step(2);
    chk("R5 ref alone keeps hold", hold, 1'b1);
    chk("R6 no reset before event", fbrst, 1'b0);
    evt = 1'b1;
    step(1);
    evt = 1'b0;
    chk("R6 hiz released", cp_hiz, 1'b0);
    chk("R6 hold cleared", hold, 1'b0);
    chk("R6 fb reset pulse", fbrst, 1'b1);
    step(1);
    chk("R6 fb reset one cycle", fbrst, 1'b0);
  endtask

  task automatic t_ref_present();
    do_reset();
    tc = 8'd2; dld = 1'b1;
    step(3);
    refp = 1'b1; dld = 1'b0;
    step(1);
    chk("R4 ref present no hold", hold, 1'b0);
    chk("R4 ref present no hiz", cp_hiz, 1'b0);
    chk("R4 lost set", lost, 1'b1);
    dld = 1'b1;
    step(2);
    chk("R4 lost held until lock seen", lost, 1'b1);
    step(1);
    chk("R4 lost cleared", lost, 1'b0);
  endtask

  task automatic t_unqualified();
    do_reset();
    tc = 8'd6; qen = 1'b1; refp = 1'b0; dld = 1'b1;
    step(2);
    dld = 1'b0;
    step(1);
    chk("R4 unqualified no hold", hold, 1'b0);
    chk("R4 unqualified lost", lost, 1'b1);
    // qualification off: always qualified
    qen = 1'b0; dld = 1'b1;
    step(1);
    dld = 1'b0;
    step(1);
    chk("R3 qual off enters hold", hold, 1'b1);
    refp = 1'b1; evt = 1'b1;
    step(1);
    evt = 1'b0;
    chk("R6 exit after qual-off hold", fbrst, 1'b1);
  endtask

  task automatic t_hold_disabled();
    do_reset();
    tc = 8'd2; hen = 1'b0; refp = 1'b0; dld = 1'b1;
    step(3);
    dld = 1'b0;
    step(1);
    chk("R4 disabled no hold", hold, 1'b0);
    chk("R4 disabled lost", lost, 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_lock_integrate();
    t_holdover_cycle();
    t_ref_present();
    t_unqualified();
    t_hold_disabled();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule